// File: doc/BRIEF.md
# Edge-Capturing Interrupt Relay

This block sits between a set of interrupt sources and a primary interrupt controller that may be switched off during deep sleep. While its enable bit is clear it is transparent. Each synchronized input appears on the matching output unless that line is masked. Before the primary controller is powered down, software sets the enable bit. From then on, edge-sensitive lines are watched and every qualifying edge is latched into a per-line pending bit, so it is not lost while nobody is listening.

Once the primary controller is powered again, software writes the flush bit. Every pending line then produces a single one-clock pulse on its output, and its pending bit is cleared. Software then clears the enable bit to return to pass-through. Level-sensitive lines never need recording, because their level is still present on wake-up. A mode bit selects whether they keep being forwarded during the enabled phase or are held quiet. Per-line mask, sensitivity and polarity are programmed through paired set and clear words on a simple memory-mapped bus. The line count is a parameter of up to 512.

Top module: `edge_hold_relay`

## Requirements
- R1: After reset the control word reads 0, and every mask and sensitivity word reads 0 (all lines unmasked and edge-sensitive). Every polarity word reads all ones for implemented lines (active-high / rising), and all outputs are low.
- R2: With control bit 0 (enable) clear, `irqOut[n]` equals `irqIn[n]` delayed by two clock edges, for every unmasked line. No edge is recorded, so a later flush produces no pulse.
- R3: A masked line never drives its output from its input, in any mode, and never records an edge.
- R4: Byte offsets 0x0C0/0x100 set/clear mask bits, 0x180/0x1C0 set/clear sensitivity bits, and 0x240/0x280 set/clear polarity bits. Line n is bit n%32 of the word at offset + 4*(n/32). Written one bits act, zero bits change nothing, and both offsets of a pair read the current bank state. Words past the line count read 0.
- R5: The control word at 0x300 holds enable in bit 0 and edge-only mode in bit 1, both reading back as written. Bit 2 is the flush command; it acts for the write cycle only and always reads 0.
- R6: With enable set, an unmasked line whose sensitivity bit is 0 records a rising edge when its polarity bit is 1 and a falling edge when it is 0. Such a line's output stays low except for flush pulses.
- R7: A line whose sensitivity bit is 1 is never recorded. While enabled, it is forwarded to its output when control bit 1 is set, and held low when control bit 1 is clear.
- R8: In the cycle after a flush write, each pending line pulses high for exactly one clock and its pending bit is cleared, so an immediate second flush gives no pulse.
- R9: An edge recorded on the same clock edge as a flush is kept pending and is replayed by the next flush, not the current one.
- R10: Several qualifying edges on one line between flushes produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one word per cycle |
| busAddr | input | 10 | Byte address; bits 1:0 must be zero |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, same cycle |
| irqIn | input | NUM_LINES | Interrupt sources, asynchronous |
| irqOut | output | NUM_LINES | Lines toward the primary controller |

## Verification
The assertions assume that a line's configuration is stable while it has a possible edge in flight, and that writes arrive as single-cycle strobes with word-aligned addresses. The stimulus therefore changes mask, sensitivity and polarity only while the inputs are quiet. It drives every bus access through one task that raises the write strobe for exactly one clock. It changes inputs only at the falling clock edge and holds each level for at least three cycles, except for the deliberate case where an edge is aligned with a flush.

// File: rtl/edge_hold_pkg.sv
package edge_hold_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  // bank code = address bits 9:6 (each bank spans 16 words = 512 lines)
  localparam logic [3:0] BANK_MASK_SET  = 4'd3;   // 0x0C0
  localparam logic [3:0] BANK_MASK_CLR  = 4'd4;   // 0x100
  localparam logic [3:0] BANK_SENSE_SET = 4'd6;   // 0x180
  localparam logic [3:0] BANK_SENSE_CLR = 4'd7;   // 0x1C0
  localparam logic [3:0] BANK_POL_SET   = 4'd9;   // 0x240
  localparam logic [3:0] BANK_POL_CLR   = 4'd10;  // 0x280
  localparam logic [3:0] BANK_CTRL      = 4'd12;  // 0x300

  typedef struct packed {
    logic enable;    // record mode
    logic edgeOnly;  // forward level lines while recording
    logic flush;     // one-cycle replay command
  } ctlStrobes_t;
endpackage

// File: rtl/ehr_ctrl.sv
module ehr_ctrl
  import edge_hold_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output ctlStrobes_t          ctlStb,
  output logic [NUM_LINES-1:0] maskVec,
  output logic [NUM_LINES-1:0] senseVec,
  output logic [NUM_LINES-1:0] polVec
);
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32;
  localparam int PAD       = NUM_WORDS * 32;

  logic [3:0] bankSel;
  logic [3:0] wordSel;
  logic       aligned;
  logic       wordHit;
  logic [NUM_LINES-1:0] lineHit;
  logic [NUM_LINES-1:0] maskQ, senseQ, polQ;
  logic       enableQ, edgeOnlyQ;
  logic       ctrlWr;

  assign bankSel = addr[9:6];
  assign wordSel = addr[5:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wordHit = aligned && (int'(wordSel) < NUM_WORDS);
  assign ctrlWr  = wrEn && aligned && (bankSel == BANK_CTRL) && (wordSel == 4'd0);

  // which lines a write word addresses with a one bit
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      lineHit[i] = wrEn && wordHit && (wordSel == 4'(i / 32)) && wrData[i % 32];
  end

  function automatic logic [NUM_LINES-1:0] bankSet(input logic [3:0] code);
    return (bankSel == code) ? lineHit : '0;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      senseQ <= '0;
      polQ   <= '1;
    end else begin
      maskQ  <= (maskQ  | bankSet(BANK_MASK_SET))  & ~bankSet(BANK_MASK_CLR);
      senseQ <= (senseQ | bankSet(BANK_SENSE_SET)) & ~bankSet(BANK_SENSE_CLR);
      polQ   <= (polQ   | bankSet(BANK_POL_SET))   & ~bankSet(BANK_POL_CLR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      edgeOnlyQ <= 1'b0;
    end else if (ctrlWr) begin
      enableQ   <= wrData[0];
      edgeOnlyQ <= wrData[1];
    end
  end

  assign ctlStb.enable   = enableQ;
  assign ctlStb.edgeOnly = edgeOnlyQ;
  assign ctlStb.flush    = ctrlWr && wrData[2];

  function automatic logic [31:0] pickWord(input logic [PAD-1:0] v, input logic [3:0] idx);
    logic [31:0] r;
    r = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (idx == 4'(w)) r = v[w*32 +: 32];
    return r;
  endfunction

  always_comb begin
    rdData = '0;
    if (aligned) begin
      unique case (bankSel)
        BANK_MASK_SET,  BANK_MASK_CLR:  if (wordHit) rdData = pickWord(PAD'(maskQ), wordSel);
        BANK_SENSE_SET, BANK_SENSE_CLR: if (wordHit) rdData = pickWord(PAD'(senseQ), wordSel);
        BANK_POL_SET,   BANK_POL_CLR:   if (wordHit) rdData = pickWord(PAD'(polQ), wordSel);
        BANK_CTRL: if (wordSel == 4'd0) rdData = {29'b0, 1'b0, edgeOnlyQ, enableQ};
        default: rdData = '0;
      endcase
    end
  end

  assign maskVec  = maskQ;
  assign senseVec = senseQ;
  assign polVec   = polQ;
endmodule

// File: rtl/ehr_datapath.sv
module ehr_datapath
  import edge_hold_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  ctlStrobes_t          ctlStb,
  input  logic [NUM_LINES-1:0] maskVec,
  input  logic [NUM_LINES-1:0] senseVec,
  input  logic [NUM_LINES-1:0] polVec,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] pendingOut,
  output logic [NUM_LINES-1:0] pulseOut
);
  logic [NUM_LINES-1:0] syncA, syncB, prevQ;
  logic [NUM_LINES-1:0] pendQ, pulseQ;
  logic [NUM_LINES-1:0] rising, falling, qualEdge, capture;
  logic [NUM_LINES-1:0] levelFwd, bypass;

  assign rising   = syncB & ~prevQ;
  assign falling  = ~syncB & prevQ;
  assign qualEdge = (polVec & rising) | (~polVec & falling);
  assign capture  = qualEdge & ~senseVec & ~maskVec & {NUM_LINES{ctlStb.enable}};
  assign levelFwd = syncB & senseVec & ~maskVec & {NUM_LINES{ctlStb.edgeOnly}};
  assign bypass   = syncB & ~maskVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevQ  <= '0;
      pendQ  <= '0;
      pulseQ <= '0;
    end else begin
      syncA  <= irqIn;
      syncB  <= syncA;
      prevQ  <= syncB;
      // a capture on the flush edge survives into the next round
      pendQ  <= (ctlStb.flush ? '0 : pendQ) | capture;
      pulseQ <= ctlStb.flush ? pendQ : '0;
    end
  end

  assign irqOut     = pulseQ | (ctlStb.enable ? levelFwd : bypass);
  assign pendingOut = pendQ;
  assign pulseOut   = pulseQ;
endmodule

// File: rtl/edge_hold_relay.sv
module edge_hold_relay
  import edge_hold_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);
  ctlStrobes_t          ctlStb;
  logic [NUM_LINES-1:0] maskVec, senseVec, polVec;
  logic [NUM_LINES-1:0] pendVec, pulseVec;

  ehr_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .rdData(busRdData), .ctlStb(ctlStb), .maskVec(maskVec), .senseVec(senseVec),
    .polVec(polVec)
  );

  ehr_datapath #(.NUM_LINES(NUM_LINES)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ctlStb(ctlStb), .maskVec(maskVec),
    .senseVec(senseVec), .polVec(polVec), .irqOut(irqOut), .pendingOut(pendVec),
    .pulseOut(pulseVec)
  );
endmodule

// File: rtl/ehr_checker.sv
module ehr_checker
  import edge_hold_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input ctlStrobes_t          ctlStb,
  input logic [NUM_LINES-1:0] maskVec,
  input logic [NUM_LINES-1:0] senseVec,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] pulseVec,
  input logic [NUM_LINES-1:0] irqOut
);
  // R2: nothing is recorded while pass-through is active
  p_no_record_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlStb.enable && !ctlStb.flush) |=> (pendVec == $past(pendVec)));

  // R3: masked lines stay silent in pass-through
  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStb.enable |-> ((irqOut & maskVec & ~pulseVec) == '0));

  // R7: level-sensitive lines never become newly pending
  p_level_not_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStb.flush |=> ((pendVec & ~$past(pendVec) & $past(senseVec)) == '0));

  // R7: quiet recording mode drives only replay pulses
  p_quiet_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.enable && !ctlStb.edgeOnly) |-> ((irqOut & ~pulseVec) == '0));

  // R8: a flush replays exactly the pending set
  p_replay_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.flush |=> (pulseVec == $past(pendVec)));

  // R8: pulses appear only right after a flush
  p_pulse_after_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseVec) |-> $past(ctlStb.flush));
endmodule

bind edge_hold_relay ehr_checker #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rstN(rstN), .ctlStb(ctlStb), .maskVec(maskVec), .senseVec(senseVec),
  .pendVec(pendVec), .pulseVec(pulseVec), .irqOut(irqOut)
);

// File: tb/edge_hold_relay_tb_top.sv
module edge_hold_relay_tb_top;
  localparam int LINES = 64;
  localparam int NSTEPS = 23;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWrEn = 1'b0;
  logic [9:0]       busAddr = '0;
  logic [31:0]      busWrData = '0;
  logic [31:0]      busRdData;
  logic [LINES-1:0] irqIn = '0;
  logic [LINES-1:0] irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  edge_hold_relay #(.NUM_LINES(LINES)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  // {isRead, req, addr, data/expected}
  localparam logic [46:0] STEPS [NSTEPS] = '{
    {1'b1, 4'd1, 10'h300, 32'h0000_0000},  // R1 control
    {1'b1, 4'd1, 10'h0C0, 32'h0000_0000},  // R1 mask
    {1'b1, 4'd1, 10'h1C4, 32'h0000_0000},  // R1 sensitivity
    {1'b1, 4'd1, 10'h240, 32'hFFFF_FFFF},  // R1 polarity
    {1'b1, 4'd1, 10'h284, 32'hFFFF_FFFF},  // R1 polarity word 1
    {1'b0, 4'd4, 10'h0C4, 32'h0000_8001},  // R4 set lines 32,47
    {1'b1, 4'd4, 10'h104, 32'h0000_8001},  // R4 read via clear offset
    {1'b1, 4'd4, 10'h0C0, 32'h0000_0000},  // R4 other word untouched
    {1'b0, 4'd4, 10'h104, 32'h0000_0001},  // R4 clear line 32
    {1'b1, 4'd4, 10'h0C4, 32'h0000_8000},
    {1'b0, 4'd4, 10'h100, 32'h0000_0000},  // R4 zero bits no effect
    {1'b1, 4'd4, 10'h0C4, 32'h0000_8000},
    {1'b0, 4'd4, 10'h104, 32'h0000_8000},
    {1'b1, 4'd4, 10'h0C4, 32'h0000_0000},
    {1'b0, 4'd4, 10'h280, 32'h0000_00F0},  // R4 polarity clear 4..7
    {1'b1, 4'd4, 10'h240, 32'hFFFF_FF0F},
    {1'b0, 4'd4, 10'h240, 32'h0000_00F0},
    {1'b1, 4'd4, 10'h280, 32'hFFFF_FFFF},
    {1'b1, 4'd4, 10'h0C8, 32'h0000_0000},  // R4 word past line count
    {1'b0, 4'd5, 10'h300, 32'h0000_0007},  // R5 enable+mode+flush
    {1'b1, 4'd5, 10'h300, 32'h0000_0003},  // R5 flush reads 0
    {1'b0, 4'd5, 10'h300, 32'h0000_0000},
    {1'b1, 4'd5, 10'h300, 32'h0000_0000}
  };

  task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] bitOf(input int n);
    return 64'd1 << n;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic [63:0] pat;
    settle(3);
    rstN = 1'b1;
    settle(1);
    check(1, "outputs after reset", irqOut, '0);

    // register table (R1, R4, R5)
    for (int k = 0; k < NSTEPS; k++) begin
      if (STEPS[k][46]) begin
        busRead(STEPS[k][41:32], rd);
        check(int'(STEPS[k][45:42]), $sformatf("table step %0d", k), 64'(rd), 64'(STEPS[k][31:0]));
      end else begin
        busWrite(STEPS[k][41:32], STEPS[k][31:0]);
      end
    end

    // R2: pass-through with two-edge latency
    pat = 64'hA5A5_0000_0000_3C3C;
    @(negedge clk) irqIn = pat;
    @(negedge clk) check(2, "bypass after one edge", irqOut, '0);
    @(negedge clk) check(2, "bypass after two edges", irqOut, pat);
    // R3: masking line 2 in bypass
    busWrite(10'h0C0, 32'h4);
    check(3, "masked line in bypass", irqOut, pat & ~bitOf(2));
    busWrite(10'h100, 32'h4);
    irqIn = '0;
    settle(3);
    busWrite(10'h300, 32'h4);  // flush while disabled
    check(2, "no replay after bypass edges", irqOut, '0);
    settle(1);
    check(2, "still quiet", irqOut, '0);

    // R6/R7: recording with edge-only forwarding
    busWrite(10'h280, 32'h2);        // line 1 falling
    busWrite(10'h184, 32'h100);      // line 40 level
    busWrite(10'h0C0, 32'h8);        // line 3 masked
    busWrite(10'h300, 32'h3);
    @(negedge clk) irqIn = bitOf(0) | bitOf(1) | bitOf(3) | bitOf(40);
    settle(4);
    check(7, "level line forwarded, edge lines low", irqOut, bitOf(40));
    irqIn[1] = 1'b0;
    settle(4);
    check(6, "edge lines held low while recording", irqOut, bitOf(40));
    busWrite(10'h300, 32'h7);
    check(6, "replay rising(0) and falling(1), not masked(3)", irqOut, bitOf(0) | bitOf(1) | bitOf(40));
    settle(1);
    check(8, "pulse lasts one clock", irqOut, bitOf(40));
    busWrite(10'h300, 32'h7);
    check(8, "second flush replays nothing", irqOut, bitOf(40));

    // R7: quiet mode and level lines never recorded
    busWrite(10'h300, 32'h1);
    check(7, "level line held low in quiet mode", irqOut, '0);
    irqIn[40] = 1'b0; settle(4);
    irqIn[40] = 1'b1; settle(4);
    busWrite(10'h300, 32'h5);
    check(7, "level edge not recorded", irqOut, '0);

    // R10: two edges on line 0 collapse to one pulse
    irqIn[0] = 1'b0; settle(3);
    irqIn[0] = 1'b1; settle(3);
    irqIn[0] = 1'b0; settle(3);
    irqIn[0] = 1'b1; settle(3);
    busWrite(10'h300, 32'h5);
    check(10, "single pulse for repeated edges", irqOut, bitOf(0));
    settle(1);
    check(10, "pulse ends", irqOut, '0);
    busWrite(10'h300, 32'h5);
    check(10, "no second pulse", irqOut, '0);

    // R9: edge on the flush edge is deferred
    @(negedge clk) irqIn[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 10'h300; busWrData = 32'h5;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    check(9, "coincident edge not replayed now", irqOut, '0);
    busWrite(10'h300, 32'h5);
    check(9, "coincident edge replayed next flush", irqOut, bitOf(5));

    // R2/R3: back to pass-through, line 3 still masked
    busWrite(10'h300, 32'h0);
    settle(3);
    check(3, "bypass resumes with mask", irqOut, irqIn & ~bitOf(3));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule